// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire serial bus. It gives a bus master read and write access to a bank of 8-bit registers that sits outside the block. Both bus lines are brought into the system clock domain through two-flop synchronizers. The block then watches for start, repeated-start and stop conditions and clocks bytes in on each rising SCL edge. It answers only to the 7-bit device address whose upper six bits are `110100` and whose lowest bit is set by a strap pin. SDA is driven open-drain: when `sda_oe_o` is high, the pad pulls the line low.

A write transaction sends the device address with the direction bit at 0, then a sub-address byte, then data bytes. Bits 6:0 of the sub-address load a register pointer. Bit 7 of the sub-address decides whether that pointer steps by one after each data byte. Each data byte leaves the block as a one-cycle write strobe with the register address and the data. A read transaction first writes the sub-address, then sends a repeated start and the device address with the direction bit at 1. The block then shifts out the contents of the register selected by the pointer, MSB first. It continues until the master answers a byte with NACK.

Top module: `i2c_rs_slave`

## Requirements
- R1: The block acknowledges an address byte whose bits 7:1 equal `{110100, addr_strap_i}`, in either direction. With the strap low, these bytes are D0h and D1h. With the strap high, they are D2h and D3h. To acknowledge, the block holds SDA low through the whole high phase of the ninth SCL pulse.
- R2: On an address mismatch the block gives no acknowledge and makes no writes. It ignores the bus until the next START. A repeated START that carries a matching address is served normally.
- R3: After a write-direction address, the next byte is the sub-address and it is acknowledged. Each later byte causes exactly one `reg_we_o` pulse of one cycle. During that pulse, `reg_addr_o` equals the pointer and `reg_wdata_o` equals the byte. Each data byte is acknowledged.
- R4: If sub-address bit 7 is 1, the pointer steps by one after each data byte in both write and read bursts. If bit 7 is 0, every byte of the burst uses the same register.
- R5: With auto-increment on, the pointer wraps from 7Fh to 00h.
- R6: After a repeated START with the read bit set, the block drives the selected register MSB first. SDA changes only while SCL is low.
- R7: In a read burst, a master ACK (SDA low on the ninth clock) makes the block send the next byte. A master NACK makes the block release SDA until the next START or STOP, so any further clocks read back as all ones.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle from any state, including the middle of a byte. A partial byte is discarded. Bytes clocked after a STOP and without a new START are not acknowledged.
- R9: `sda_oe_o` never changes while SCL is high.
- R10: Out of reset, `sda_oe_o` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (resolved bus level) |
| addr_strap_i | input | 1 | Strap that sets device address bit 0 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 7 | Register pointer (write address and read select) |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` |

## Verification
The hardest states to reach from the pins are the ones where the master abandons the normal byte flow. These include a STOP that arrives four bits into a data byte, a NACK followed by further SCL pulses, and a mismatched address that is recovered by a repeated START within the same bus ownership. The bench drives the bus bit by bit through its own master tasks, so it can cut a byte short, keep clocking after a NACK, or send a byte without any START. For each of these cases it checks that no write strobe occurs, that SDA stays released, and that the next proper transaction still works.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges count only while SCL is steadily high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          load_inc_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic          inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      inc_q <= 1'b0;
    end else if (load_i) begin
      ptr_q <= load_addr_i;
      inc_q <= load_inc_i;
    end else if (adv_i && inc_q) begin
      ptr_q <= ptr_q + 1'b1;  // natural wrap at the top
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_rs_slave.sv
module i2c_rs_slave #(
  parameter logic [5:0] ADDR_HI     = 6'b110100,
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [BYTE_W-2:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  import i2c_rs_pkg::*;

  localparam int RAW   = BYTE_W - 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_rs_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, wdata_q;
  logic              rw_q, mack_q, we_q;
  logic              byte_done, ptr_load, ptr_adv;

  assign byte_done = scl_fall && (cnt_q == CNT_FULL);
  assign ptr_load  = (state_q == ST_SUB) && byte_done && !start_det && !stop_det;
  assign ptr_adv   = ((state_q == ST_WDATA_ACK) && scl_fall) ||
                     ((state_q == ST_TX_ACK) && scl_rise && !sda_s);

  i2c_rs_ptr #(.AW(RAW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_addr_i(rx_q[RAW-1:0]),
    .load_inc_i (rx_q[BYTE_W-1]),
    .adv_i      (ptr_adv),
    .ptr_o      (reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      wdata_q <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (rx_q[BYTE_W-1:1] == {ADDR_HI, addr_strap_i}) begin
                  rw_q    <= rx_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_SUB) begin
                state_q <= ST_SUB_ACK;
              end else begin
                state_q <= ST_WDATA_ACK;
                we_q    <= 1'b1;
                wdata_q <= rx_q;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q <= ST_TX;
                tx_q    <= reg_rdata_i;
              end else begin
                state_q <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) state_q <= ST_WDATA;
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) state_q <= ST_TX_ACK;
              else tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= !sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                // pointer stepped at the rising edge; rdata is settled here
                state_q <= ST_TX;
                tx_q    <= reg_rdata_i;
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_TX:                                 sda_oe_o = !tx_q[BYTE_W-1];
      default:                               sda_oe_o = 1'b0;
    endcase
  end

  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
endmodule

// File: rtl/i2c_rs_slave_chk.sv
module i2c_rs_slave_chk (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scl_i,
  input logic                 sda_oe_o,
  input logic                 reg_we_o,
  input logic [6:0]           reg_addr_o,
  input logic                 stop_i,
  input i2c_rs_pkg::state_e   state_i
);
  a_r9_oe_moves_with_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r3_we_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r3_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> sda_oe_o);

  a_r3_addr_steady_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $stable(reg_addr_o));

  a_r8_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == i2c_rs_pkg::ST_IDLE));

  a_r7_released_after_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == i2c_rs_pkg::ST_IGNORE) |-> !sda_oe_o);
endmodule

bind i2c_rs_slave i2c_rs_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o),
  .stop_i    (stop_det),
  .state_i   (state_q)
);

// File: tb/i2c_rs_slave_tb.sv
module i2c_rs_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 16;
  localparam int QTR  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic       sda_oe, we, sda_bus;
  logic [6:0] raddr;
  logic [7:0] wdata, rdata;

  logic [7:0] rf      [128];
  logic [7:0] exp_mem [128];
  logic [14:0] wq [$];
  int   mptr = 0;
  bit   minc = 1'b0;
  int   n_cmp = 0, n_err = 0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_rs_slave u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .addr_strap_i(strap),
    .sda_oe_o    (sda_oe),
    .reg_we_o    (we),
    .reg_addr_o  (raddr),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata)
  );

  // register bank seen by the block
  always @(posedge clk) if (we) rf[raddr] <= wdata;
  assign rdata = rf[raddr];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the write queue and the SDA rule
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (wq.size() == 0) chk("R3 unexpected write strobe", {raddr, wdata}, 0);
        else chk("R3/R4 write address and data", {raddr, wdata}, wq.pop_front());
      end
      if (sda_oe !== prev_oe) chk("R9 sda_oe change with SCL high", scl_m, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model
  task automatic m_sub(input logic [7:0] b);
    mptr = int'(b[6:0]);
    minc = b[7];
  endtask
  task automatic m_adv();
    if (minc) mptr = (mptr + 1) % 128;
  endtask
  task automatic m_wr(input logic [7:0] d);
    wq.push_back({7'(mptr), d});
    exp_mem[mptr] = d;
    m_adv();
  endtask

  // bus master
  task automatic bus_start();
    sda_m = 1'b0; waitc(HALF);
    scl_m = 1'b0; waitc(QTR);
  endtask
  task automatic bus_rstart();
    sda_m = 1'b1; waitc(QTR);
    scl_m = 1'b1; waitc(HALF);
    sda_m = 1'b0; waitc(HALF);
    scl_m = 1'b0; waitc(QTR);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; waitc(QTR);
    scl_m = 1'b1; waitc(HALF);
    sda_m = 1'b1; waitc(HALF);
  endtask
  task automatic send_bit(input logic b);
    sda_m = b;    waitc(QTR);
    scl_m = 1'b1; waitc(HALF);
    scl_m = 1'b0; waitc(QTR);
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1'b1; waitc(QTR);
    scl_m = 1'b1; waitc(QTR);
    b = sda_bus;  waitc(QTR);
    scl_m = 1'b0; waitc(QTR);
  endtask
  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic read_byte(output logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(!ack);
  endtask

  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] sub, input logic [7:0] d0,
                        input int n, input bit match, input string tag);
    bit ack;
    bus_start();
    write_byte(dev, ack);
    chk({tag, " address ack"}, ack, match);
    if (match) m_sub(sub);
    write_byte(sub, ack);
    chk({tag, " sub-address ack"}, ack, match);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = d0 + 8'(i * 37);
      if (match) m_wr(d);
      write_byte(d, ack);
      chk({tag, " data ack"}, ack, match);
    end
    bus_stop();
    chk({tag, " all writes seen"}, wq.size(), 0);
  endtask

  task automatic rd_seq(input logic [7:0] dev, input logic [7:0] sub, input int n,
                        input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    write_byte(dev, ack);
    chk({tag, " address ack"}, ack, 1);
    m_sub(sub);
    write_byte(sub, ack);
    chk({tag, " sub-address ack"}, ack, 1);
    bus_rstart();
    write_byte(dev | 8'h01, ack);
    chk({tag, " read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_mem[mptr];
      read_byte(d, i < n - 1);
      chk({tag, " read data"}, d, e);
      if (i < n - 1) m_adv();
    end
    read_byte(d, 1'b0);
    chk("R7 bus released after NACK", d, 8'hFF);
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    waitc(5);
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 reg_we after reset", we, 0);
    rst_n = 1'b1;
    waitc(10);
    chk("R10 sda_oe idle", sda_oe, 0);

    strap = 1'b0;
    wr_seq(8'hD0, 8'h85, 8'hA1, 3, 1'b1, "R1 R3 R4 burst");
    wr_seq(8'hD0, 8'h10, 8'h11, 2, 1'b1, "R4 fixed pointer");
    wr_seq(8'hD0, 8'hFE, 8'h01, 3, 1'b1, "R5 wrap write");

    strap = 1'b1;
    wr_seq(8'hD0, 8'h05, 8'h99, 2, 1'b0, "R2 mismatch");
    wr_seq(8'hD2, 8'h20, 8'h5A, 1, 1'b1, "R1 strap high");

    // R2: mismatch then repeated start with the matching address
    bus_start();
    write_byte(8'hD4, ack);
    chk("R2 mismatch nack", ack, 0);
    write_byte(8'h41, ack);
    chk("R2 ignored byte nack", ack, 0);
    bus_rstart();
    write_byte(8'hD2, ack);
    chk("R2 recovered on repeated start", ack, 1);
    m_sub(8'h40);
    write_byte(8'h40, ack);
    m_wr(8'h3C);
    write_byte(8'h3C, ack);
    chk("R2 data after recovery ack", ack, 1);
    bus_stop();
    chk("R2 writes after recovery seen", wq.size(), 0);

    rd_seq(8'hD2, 8'h85, 3, "R6 R7 read burst");
    rd_seq(8'hD2, 8'h10, 2, "R4 fixed read");
    rd_seq(8'hD2, 8'hFF, 2, "R5 wrap read");
    strap = 1'b0;
    rd_seq(8'hD0, 8'h20, 1, "R1 R6 single read");

    // R8: stop inside a data byte, then bytes without a start
    strap = 1'b1;
    bus_start();
    write_byte(8'hD2, ack);
    m_sub(8'h30);
    write_byte(8'h30, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    waitc(HALF);
    chk("R8 partial byte discarded", wq.size(), 0);
    scl_m = 1'b0; waitc(QTR);
    write_byte(8'hD2, ack);
    chk("R8 no ack without start", ack, 0);
    sda_m = 1'b1; waitc(QTR);
    scl_m = 1'b1; waitc(HALF);
    wr_seq(8'hD2, 8'h31, 8'h77, 1, 1'b1, "R8 after stop");
    rd_seq(8'hD2, 8'h31, 1, "R8 readback");
    chk("R8 register 30h untouched", rf[7'h30] === 8'h77 ? 1 : 0, 0);

    waitc(20);
    summary();
    $finish;
  end
endmodule